// File: doc/BRIEF.md
# Register-Mapped Signed Integer Divider

This block is a signed integer divider that a host drives through a small set of 32-bit registers. The host loads a 64-bit numerator and a 64-bit denominator as pairs of words. It then writes a 16-bit control word, which chooses the operand widths and starts the division. While the divider works, the control word shows a busy flag. When the busy flag drops, the host reads a 64-bit quotient and a 64-bit remainder, each as two words.

The division runs on operand magnitudes with a restoring shift-subtract engine. The parameter `BPC` sets how many quotient bits are retired per clock, so one division takes 64/BPC cycles. Signs are applied at the end. A zero denominator does not stop the sequence: it runs for the normal time and then gives a defined result, with a flag that the host can read. The flag bits in the control word are owned by the divider, and a host write never changes them.

Byte offsets, as decoded from `bus_addr`: control 0x00, numerator low/high 0x10/0x14, denominator low/high 0x18/0x1C, quotient low/high 0x20/0x24, remainder low/high 0x28/0x2C. Offsets that are not mapped read as zero. `bus_size` encodes 0 = byte, 1 = halfword, 2 = word. Reads are combinational. A write takes effect at the clock edge where `bus_wr` is high.

Top module: `mmio_divider`

## Requirements
- R1: After reset, the control word reads 0 (mode 0, neither flag set) and all four result words read 0.
- R2: A halfword read of the control word returns mode in bits [1:0], the busy flag in bit 15 and the divide-by-zero flag in bit 14. Bits [13:2] and [31:16] read 0.
- R3: A halfword control write loads only the mode from write bits [1:0]. The values of write bits 15 and 14 have no effect on the busy and divide-by-zero flags.
- R4: Every halfword control write starts a division. From that edge, busy reads 1, the divide-by-zero flag reads 0 and all four result words read 0 until the division completes.
- R5: Busy stays set for exactly 64/BPC cycles after the starting edge. Busy then clears and the quotient and remainder appear in the same cycle.
- R6: Mode 0 divides the low numerator word by the low denominator word, each sign-extended to 64 bits.
- R7: Modes 1 and 3 divide the full 64-bit numerator by the sign-extended low denominator word.
- R8: Mode 2 divides the full 64-bit numerator by the full 64-bit denominator.
- R9: The quotient truncates toward zero and the remainder takes the sign of the numerator. The case of the most negative numerator divided by -1 gives a quotient equal to the most negative value and a remainder of 0.
- R10: When the selected denominator is zero, the quotient is +1 for a negative numerator and -1 otherwise, the remainder equals the selected numerator, and the divide-by-zero flag is set at completion.
- R11: Byte and word accesses to the control word are rejected. Such reads return 0 and such writes neither change the mode nor start a division.
- R12: A control write while busy restarts the division with the new mode and the present operand registers. The full latency counts again from that write, including a write that lands on the completing edge.
- R13: The operand registers read back what was written, at any access size. Writes to the result words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 6 | Byte offset of the register |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |

## Verification
Two things can happen on the same edge: the engine retires its last quotient bit, and the host writes the control word again. A restart has to win. Busy must stay set, the results must stay zero, and the flag must not take the value from the finished run. The bench provokes this by placing a control write exactly 64/BPC cycles after a start. It then checks that busy is still high and the quotient word still reads zero. It waits a full latency again and compares the result against the operands of the second run.

// File: rtl/div_pkg.sv
`timescale 1ns/10ps
package div_pkg;

    localparam int WORD_W = 32;
    localparam int DATA_W = 64;
    localparam int ADDR_W = 6;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        MD_S32_S32 = 2'd0,
        MD_S64_S32 = 2'd1,
        MD_S64_S64 = 2'd2,
        MD_S64_S32X = 2'd3
    } div_mode_e;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_NUM_LO = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_NUM_HI = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_DEN_LO = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_DEN_HI = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_QUO_LO = 6'h20;
    localparam logic [ADDR_W-1:0] OFS_QUO_HI = 6'h24;
    localparam logic [ADDR_W-1:0] OFS_REM_LO = 6'h28;
    localparam logic [ADDR_W-1:0] OFS_REM_HI = 6'h2C;

    typedef struct packed {
        logic [DATA_W-1:0] num;
        logic [DATA_W-1:0] den;
    } operands_t;

    typedef struct packed {
        logic neg_num;
        logic neg_den;
        logic den_zero;
    } sign_info_t;

    function automatic logic [DATA_W-1:0] sext_word(input logic [WORD_W-1:0] v);
        return {{(DATA_W-WORD_W){v[WORD_W-1]}}, v};
    endfunction

    function automatic logic [DATA_W-1:0] magnitude(input logic [DATA_W-1:0] v);
        return v[DATA_W-1] ? (~v + 1'b1) : v;
    endfunction

    function automatic operands_t pick_operands(input div_mode_e m,
                                                input logic [WORD_W-1:0] nlo,
                                                input logic [WORD_W-1:0] nhi,
                                                input logic [WORD_W-1:0] dlo,
                                                input logic [WORD_W-1:0] dhi);
        operands_t o;
        case (m)
            MD_S32_S32: begin
                o.num = sext_word(nlo);
                o.den = sext_word(dlo);
            end
            MD_S64_S64: begin
                o.num = {nhi, nlo};
                o.den = {dhi, dlo};
            end
            default: begin
                o.num = {nhi, nlo};
                o.den = sext_word(dlo);
            end
        endcase
        return o;
    endfunction

endpackage

// File: rtl/div_regs.sv
`timescale 1ns/10ps
module div_regs
    import div_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  acc_size_e           bus_size,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic                busy,
    input  logic                dz,
    input  logic [DATA_W-1:0]   quo,
    input  logic [DATA_W-1:0]   rem,
    output logic                start,
    output div_mode_e           start_mode,
    output div_mode_e           mode,
    output logic [WORD_W-1:0]   num_lo,
    output logic [WORD_W-1:0]   num_hi,
    output logic [WORD_W-1:0]   den_lo,
    output logic [WORD_W-1:0]   den_hi
);

    logic ctrl_ok;

    // control word only answers halfword accesses
    assign ctrl_ok    = (bus_addr == OFS_CTRL) && (bus_size == SZ_HALF);
    assign start      = bus_wr && ctrl_ok;
    assign start_mode = div_mode_e'(bus_wdata[1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode   <= MD_S32_S32;
            num_lo <= '0;
            num_hi <= '0;
            den_lo <= '0;
            den_hi <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_CTRL:   if (ctrl_ok) mode <= start_mode;
                OFS_NUM_LO: num_lo <= bus_wdata;
                OFS_NUM_HI: num_hi <= bus_wdata;
                OFS_DEN_LO: den_lo <= bus_wdata;
                OFS_DEN_HI: den_hi <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (bus_addr)
            OFS_CTRL:   bus_rdata = ctrl_ok ? {16'h0, busy, dz, 12'h0, mode} : '0;
            OFS_NUM_LO: bus_rdata = num_lo;
            OFS_NUM_HI: bus_rdata = num_hi;
            OFS_DEN_LO: bus_rdata = den_lo;
            OFS_DEN_HI: bus_rdata = den_hi;
            OFS_QUO_LO: bus_rdata = quo[WORD_W-1:0];
            OFS_QUO_HI: bus_rdata = quo[DATA_W-1:WORD_W];
            OFS_REM_LO: bus_rdata = rem[WORD_W-1:0];
            OFS_REM_HI: bus_rdata = rem[DATA_W-1:WORD_W];
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/div_fixup.sv
`timescale 1ns/10ps
module div_fixup
    import div_pkg::*;
(
    input  sign_info_t          sinfo,
    input  logic [DATA_W-1:0]   num_orig,
    input  logic [DATA_W-1:0]   q_mag,
    input  logic [DATA_W-1:0]   r_mag,
    output logic [DATA_W-1:0]   quo,
    output logic [DATA_W-1:0]   rem
);

    always_comb begin
        if (sinfo.den_zero) begin
            quo = sinfo.neg_num ? {{(DATA_W-1){1'b0}}, 1'b1} : {DATA_W{1'b1}};
            rem = num_orig;
        end else begin
            quo = (sinfo.neg_num ^ sinfo.neg_den) ? (~q_mag + 1'b1) : q_mag;
            rem = sinfo.neg_num ? (~r_mag + 1'b1) : r_mag;
        end
    end

endmodule

// File: rtl/div_core.sv
`timescale 1ns/10ps
module div_core
    import div_pkg::*;
#(
    parameter int BPC = 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  div_mode_e           start_mode,
    input  logic [WORD_W-1:0]   num_lo,
    input  logic [WORD_W-1:0]   num_hi,
    input  logic [WORD_W-1:0]   den_lo,
    input  logic [WORD_W-1:0]   den_hi,
    output logic                busy,
    output logic                dz,
    output logic [DATA_W-1:0]   quo,
    output logic [DATA_W-1:0]   rem
);

    localparam int ITER = DATA_W / BPC;
    localparam int CW   = $clog2(ITER + 1);

    operands_t               ops;
    sign_info_t              sinfo_q;
    logic [DATA_W-1:0]       acc_q, q_q, d_q, num_q;
    logic [CW-1:0]           cnt_q;
    logic [BPC:0][DATA_W-1:0] acc_s;
    logic [BPC:0][DATA_W-1:0] q_s;
    logic [DATA_W-1:0]       fix_quo, fix_rem;

    assign ops      = pick_operands(start_mode, num_lo, num_hi, den_lo, den_hi);
    assign acc_s[0] = acc_q;
    assign q_s[0]   = q_q;

    // one restoring shift-subtract stage per quotient bit retired this cycle
    for (genvar k = 0; k < BPC; k++) begin : g_stage
        logic [DATA_W:0] shifted;
        logic [DATA_W:0] trial;
        assign shifted    = {acc_s[k], q_s[k][DATA_W-1]};
        assign trial      = shifted - {1'b0, d_q};
        assign acc_s[k+1] = trial[DATA_W] ? shifted[DATA_W-1:0] : trial[DATA_W-1:0];
        assign q_s[k+1]   = {q_s[k][DATA_W-2:0], ~trial[DATA_W]};
    end

    div_fixup u_fix (
        .sinfo    (sinfo_q),
        .num_orig (num_q),
        .q_mag    (q_s[BPC]),
        .r_mag    (acc_s[BPC]),
        .quo      (fix_quo),
        .rem      (fix_rem)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            dz      <= 1'b0;
            quo     <= '0;
            rem     <= '0;
            acc_q   <= '0;
            q_q     <= '0;
            d_q     <= '0;
            num_q   <= '0;
            sinfo_q <= '0;
            cnt_q   <= '0;
        end else if (start) begin
            busy             <= 1'b1;
            dz               <= 1'b0;
            quo              <= '0;
            rem              <= '0;
            acc_q            <= '0;
            q_q              <= magnitude(ops.num);
            d_q              <= magnitude(ops.den);
            num_q            <= ops.num;
            sinfo_q.neg_num  <= ops.num[DATA_W-1];
            sinfo_q.neg_den  <= ops.den[DATA_W-1];
            sinfo_q.den_zero <= (ops.den == '0);
            cnt_q            <= CW'(ITER);
        end else if (busy) begin
            acc_q <= acc_s[BPC];
            q_q   <= q_s[BPC];
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
                busy <= 1'b0;
                quo  <= fix_quo;
                rem  <= fix_rem;
                dz   <= sinfo_q.den_zero;
            end
        end
    end

endmodule

// File: rtl/mmio_divider.sv
`timescale 1ns/10ps
module mmio_divider #(
    parameter int BPC = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [5:0]  bus_addr,
    input  logic [1:0]  bus_size,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);
    import div_pkg::*;

    logic              ctrl_start;
    div_mode_e         start_mode;
    div_mode_e         cur_mode;
    logic [WORD_W-1:0] num_lo, num_hi, den_lo, den_hi;
    logic              core_busy, core_dz;
    logic [DATA_W-1:0] core_quo, core_rem;

    div_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_size   (acc_size_e'(bus_size)),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .busy       (core_busy),
        .dz         (core_dz),
        .quo        (core_quo),
        .rem        (core_rem),
        .start      (ctrl_start),
        .start_mode (start_mode),
        .mode       (cur_mode),
        .num_lo     (num_lo),
        .num_hi     (num_hi),
        .den_lo     (den_lo),
        .den_hi     (den_hi)
    );

    div_core #(.BPC(BPC)) u_core (
        .clk        (clk),
        .rst        (rst),
        .start      (ctrl_start),
        .start_mode (start_mode),
        .num_lo     (num_lo),
        .num_hi     (num_hi),
        .den_lo     (den_lo),
        .den_hi     (den_hi),
        .busy       (core_busy),
        .dz         (core_dz),
        .quo        (core_quo),
        .rem        (core_rem)
    );

endmodule

// File: rtl/div_checker.sv
`timescale 1ns/10ps
module div_checker #(
    parameter int BPC = 1
) (
    input logic        clk,
    input logic        rst,
    input logic        bus_wr,
    input logic [5:0]  bus_addr,
    input logic [1:0]  bus_size,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        start,
    input logic        busy,
    input logic        dz,
    input logic [63:0] quo,
    input logic [63:0] rem,
    input logic [1:0]  mode
);
    localparam int ITER = 64 / BPC;

    logic [15:0] lat_cnt;

    always_ff @(posedge clk) begin
        if (rst)        lat_cnt <= '0;
        else if (start) lat_cnt <= 16'd1;
        else if (busy)  lat_cnt <= lat_cnt + 16'd1;
    end

    p_ctrl_fmt_r2: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 6'h00 && bus_size == 2'd1) |->
            (bus_rdata[31:16] == 16'h0 && bus_rdata[13:2] == 12'h0));

    p_mode_load_r3: assert property (@(posedge clk) disable iff (rst)
        start |=> (mode == $past(bus_wdata[1:0])));

    p_start_state_r4: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && !dz && quo == 64'h0 && rem == 64'h0));

    p_zero_while_busy_r4: assert property (@(posedge clk) disable iff (rst)
        busy |-> (quo == 64'h0 && rem == 64'h0));

    p_latency_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(lat_cnt) == 16'(ITER)));

    p_dz_at_done_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(dz) |-> $fell(busy));

    p_bad_size_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 6'h00 && bus_size != 2'd1 && !busy) |=> !busy);

    p_bad_size_mode_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 6'h00 && bus_size != 2'd1) |=> $stable(mode));

endmodule

bind mmio_divider div_checker #(.BPC(BPC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .start     (ctrl_start),
    .busy      (core_busy),
    .dz        (core_dz),
    .quo       (core_quo),
    .rem       (core_rem),
    .mode      (cur_mode)
);

// File: tb/sim_mmio_divider.sv
`timescale 1ns/10ps
module sim_mmio_divider;

    localparam int BPC  = 1;
    localparam int ITER = 64 / BPC;

    localparam logic [5:0] A_CTL = 6'h00, A_NL = 6'h10, A_NH = 6'h14,
                           A_DL = 6'h18, A_DH = 6'h1C, A_QL = 6'h20,
                           A_QH = 6'h24, A_RL = 6'h28, A_RH = 6'h2C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'd1;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    mmio_divider #(.BPC(BPC)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [1:0] s, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_size = s; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [1:0] s, output logic [31:0] d);
        bus_addr = a; bus_size = s;
        #0.1;
        d = bus_rdata;
    endtask

    task automatic rd64(input logic [5:0] a, output logic [63:0] d);
        logic [31:0] lo, hi;
        rd(a, 2'd2, lo);
        rd(a + 6'd4, 2'd2, hi);
        d = {hi, lo};
    endtask

    // reference arithmetic
    task automatic model(input int md, input logic [63:0] nr, input logic [63:0] dr,
                         output logic [63:0] eq, output logic [63:0] er, output logic edz);
        logic signed [63:0] n, d;
        if (md == 0) begin
            n = {{32{nr[31]}}, nr[31:0]};
            d = {{32{dr[31]}}, dr[31:0]};
        end else if (md == 2) begin
            n = nr; d = dr;
        end else begin
            n = nr; d = {{32{dr[31]}}, dr[31:0]};
        end
        edz = 1'b0;
        if (d == 0) begin
            eq = (n < 0) ? 64'd1 : 64'hFFFF_FFFF_FFFF_FFFF;
            er = n;
            edz = 1'b1;
        end else if (n == 64'sh8000_0000_0000_0000 && d == -64'sd1) begin
            eq = 64'h8000_0000_0000_0000;
            er = 64'd0;
        end else begin
            eq = n / d;
            er = n % d;
        end
    endtask

    task automatic load_ops(input logic [63:0] n, input logic [63:0] d);
        wr(A_NL, 2'd2, n[31:0]);
        wr(A_NH, 2'd2, n[63:32]);
        wr(A_DL, 2'd2, d[31:0]);
        wr(A_DH, 2'd2, d[63:32]);
    endtask

    // called right after the starting write; checks busy window and results
    task automatic finish_check(input int md, input logic [63:0] n, input logic [63:0] d,
                                input string tag);
        logic [31:0] c;
        logic [63:0] q, r, eq, er;
        logic edz;
        model(md, n, d, eq, er, edz);
        repeat (ITER - 1) @(negedge clk);
        rd(A_CTL, 2'd1, c);
        chk("R5 busy before last step", {63'd0, c[15]}, 64'd1);
        @(negedge clk);
        rd(A_CTL, 2'd1, c);
        chk("R5 ctrl at completion", {32'd0, c}, {48'd0, 1'b0, edz, 12'd0, 2'(md)});
        rd64(A_QL, q);
        rd64(A_RL, r);
        chk(edz ? "R10 quotient" : tag, q, eq);
        chk(edz ? "R10 remainder" : "R9 remainder", r, er);
    endtask

    task automatic start_div(input int md);
        logic [31:0] c;
        logic [63:0] q;
        wr(A_CTL, 2'd1, 32'(md));
        rd(A_CTL, 2'd1, c);
        chk("R4 ctrl after start", {32'd0, c}, {48'd0, 16'h8000 | 16'(md)});
        rd64(A_QL, q);
        chk("R4 quotient zero while busy", q, 64'd0);
    endtask

    localparam logic [63:0] VALS [12] = '{
        64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001,
        64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0007,
        64'hFFFF_FFFF_FFFF_FFF9, 64'h0000_0000_7FFF_FFFF,
        64'hFFFF_FFFF_8000_0000, 64'h0000_0001_2345_6789,
        64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF,
        64'h0000_0003_8000_0005, 64'hFFFF_FFFF_0000_000D
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R5 actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] c;
        logic [63:0] v, q;
        string tag;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(A_CTL, 2'd1, c);
        chk("R1 ctrl after reset", {32'd0, c}, 64'd0);
        rd64(A_QL, q);
        chk("R1 quotient after reset", q, 64'd0);
        rd64(A_RL, q);
        chk("R1 remainder after reset", q, 64'd0);

        // R3: flag bits in write data are ignored, only mode loads
        load_ops(64'd100, 64'd7);
        wr(A_CTL, 2'd1, 32'h0000_C003);
        rd(A_CTL, 2'd1, c);
        chk("R3 flags not written", {32'd0, c}, 64'h8003);
        chk("R2 reserved bits zero", {32'd0, c[31:16], 2'b0, c[13:2]}, 64'd0);
        finish_check(3, 64'd100, 64'd7, "R7 quotient");

        // R11: rejected sizes on the control word
        wr(A_CTL, 2'd0, 32'h0000_0002);
        rd(A_CTL, 2'd1, c);
        chk("R11 byte write ignored", {32'd0, c}, 64'h0003);
        wr(A_CTL, 2'd2, 32'h0000_0001);
        rd(A_CTL, 2'd1, c);
        chk("R11 word write ignored", {32'd0, c}, 64'h0003);
        rd(A_CTL, 2'd0, c);
        chk("R11 byte read zero", {32'd0, c}, 64'd0);
        rd(A_CTL, 2'd2, c);
        chk("R11 word read zero", {32'd0, c}, 64'd0);

        // R13: operand readback, result words not writable
        wr(A_NL, 2'd0, 32'hDEAD_BEEF);
        rd(A_NL, 2'd2, c);
        chk("R13 numerator readback", {32'd0, c}, 64'hDEAD_BEEF);
        wr(A_QL, 2'd2, 32'h1234_5678);
        rd64(A_QL, q);
        chk("R13 quotient write ignored", q, 64'd14);

        // R12: restart in the middle of a run
        load_ops(64'd100, 64'd7);
        start_div(1);
        repeat (20) @(negedge clk);
        wr(A_NL, 2'd2, 32'hFFFF_FFCE);
        wr(A_NH, 2'd2, 32'hFFFF_FFFF);
        start_div(2);
        finish_check(2, 64'hFFFF_FFFF_FFFF_FFCE, 64'd7, "R12 restart mid-run");

        // R12: restart on the completing edge
        load_ops(64'd1000, 64'hFFFF_FFFF_FFFF_FFFD);
        start_div(0);
        repeat (ITER - 1) @(negedge clk);
        wr(A_CTL, 2'd1, 32'h0000_0000);
        rd(A_CTL, 2'd1, c);
        chk("R12 busy after restart at completion", {32'd0, c}, 64'h8000);
        rd64(A_QL, q);
        chk("R12 quotient zero after restart", q, 64'd0);
        finish_check(0, 64'd1000, 64'hFFFF_FFFF_FFFF_FFFD, "R12 restart at completion");

        // sweep: all modes over a set of edge values
        for (int md = 0; md < 4; md++) begin
            for (int i = 0; i < 12; i++) begin
                for (int j = 0; j < 12; j++) begin
                    load_ops(VALS[i], VALS[j]);
                    start_div(md);
                    tag = (md == 0) ? "R6 quotient" : (md == 2) ? "R8 quotient" : "R7 quotient";
                    finish_check(md, VALS[i], VALS[j], tag);
                end
            end
        end

        // R9 explicit overflow case in full width
        load_ops(64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
        start_div(2);
        finish_check(2, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, "R9 min by minus one");
        rd64(A_QL, v);
        chk("R9 min by minus one quotient", v, 64'h8000_0000_0000_0000);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule